// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is the protocol layer of a two-wire serial slave that exposes a sixteen-location register space. It sits behind a pad front end that has already found the bus conditions and sampled the data line. For each SCL clock that front end gives one strobe with the sampled bit. It also reports start, repeated-start and stop conditions as single-cycle pulses. The block tells the pad when to acknowledge and which bit to drive while it transmits. It issues write and read strobes toward the register storage.

Every transaction opens with an address byte: seven address bits and then the direction bit. A write continues with a command byte, which loads the register pointer and selects one of two framings. In byte mode, data bytes are accepted one after another until stop. In block mode, a byte count comes next and bounds the number of data bytes. A read uses the combined format: a write phase that carries the command byte, a repeated start, then the address again with the read bit set. In byte mode, register bytes are returned for as long as the master acknowledges them. In block mode, a byte count goes out first.

The controller has one FSM. Its states are ST_IDLE, ST_ADDR (receive address), ST_ADDR_ACK, ST_CMD (receive command), ST_CMD_ACK, ST_CNT (receive byte count), ST_CNT_ACK, ST_WDAT (receive data), ST_WDAT_ACK, ST_TX (send byte), ST_TX_ACK (sample master acknowledge) and ST_WAIT (ignore bus until next condition). Its transitions are these:
- Start or repeated start, from any state, goes to ST_ADDR.
- Stop, from any state, goes to ST_IDLE.
- Each receive state goes to its acknowledge state on its eighth bit.
- ST_ADDR_ACK goes to ST_WAIT on a mismatch, to ST_TX on a read and to ST_CMD on a write.
- ST_CMD_ACK goes to ST_CNT in block mode and to ST_WDAT in byte mode.
- ST_CNT_ACK and ST_WDAT_ACK go to ST_WDAT.
- ST_TX goes to ST_TX_ACK after eight bits.
- ST_TX_ACK goes to ST_TX when the master acknowledges and to ST_WAIT when it does not.

Top module: `smb_reg_slave`

## Requirements
- R1: After the eight address bits, ack_o is 1 during the acknowledge slot only if bits 7:1 of the address byte equal SLV_ADDR. On a mismatch, ack_o stays 0 and all later bytes are ignored (no acknowledge, no strobe) until the next start or repeated start.
- R2: In the command byte, bits 3:0 are loaded into the register pointer, and bit 4 selects block mode (1) or byte mode (0). The command byte is always acknowledged.
- R3: In a byte-mode write, every data byte is acknowledged and written at the pointer. The pointer then increments and wraps from Fh to 0h. This continues until stop.
- R4: In a block-mode write, the byte after the command is a count N. The next N data bytes are acknowledged and written. Any further data bytes are nacked and not written.
- R5: After the read address, bytes are sent MSB first on tx_bit_o with tx_en_o high. In byte mode, each byte is the register at the pointer, the pointer then increments with wrap, and this continues while the master acknowledges.
- R6: In a block-mode read, the first byte is the count 16 minus the pointer. That many register bytes follow. After that, every further byte is FFh.
- R7: A master nack (sampled bit 1) in the acknowledge slot after a transmitted byte ends transmission. tx_en_o stays 0 until the next start or repeated start.
- R8: Addresses 0h to 6h are read/write storage. Ah reads the ID_VALUE parameter. Ch/Dh read the low/high bytes of adc0_val, and Eh/Fh the low/high bytes of adc1_val. Addresses 7h, 8h, 9h and Bh read 0. Writes to any address above 6h are acknowledged and discarded.
- R9: wr_stb_o pulses for one cycle for each accepted data byte, with reg_addr_o and wr_data_o. rd_stb_o pulses for one cycle for each register byte loaded for transmit. The two strobes never coincide.
- R10: A stop in any state returns the block to idle, with ack_o and tx_en_o low.
- R11: After reset, all outputs are 0, the storage holds 0 and the pointer is 0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_start | input | 1 | Start condition pulse |
| cond_rstart | input | 1 | Repeated start condition pulse |
| cond_stop | input | 1 | Stop condition pulse |
| bit_stb | input | 1 | One pulse per SCL clock, including acknowledge slots |
| bit_val | input | 1 | Sampled data line for the current bit |
| adc0_val | input | 16 | Conversion result, channel 0 |
| adc1_val | input | 16 | Conversion result, channel 1 |
| ack_o | output | 1 | Slave acknowledges the current acknowledge slot |
| tx_en_o | output | 1 | Slave is transmitting a data bit |
| tx_bit_o | output | 1 | Bit to drive while tx_en_o is high |
| wr_stb_o | output | 1 | Register write strobe |
| rd_stb_o | output | 1 | Register read strobe |
| reg_addr_o | output | 4 | Address of the current strobe |
| wr_data_o | output | 8 | Write data of the current strobe |

## Verification
The assertions assume well-formed input from the front end:
- condition pulses and bit strobes are never asserted in the same cycle;
- each strobe lasts exactly one cycle;
- a repeated start only arrives inside a transaction.

The stimulus keeps to these rules. It issues every condition and every bit as an isolated one-cycle pulse, starting on a falling clock edge. It always sends a full eight bits plus an acknowledge slot, except in the directed test that cuts a transfer short with a stop.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_CNT,
        ST_CNT_ACK, ST_WDAT, ST_WDAT_ACK, ST_TX, ST_TX_ACK, ST_WAIT
    } srs_state_e;
endpackage

// File: rtl/srs_bitcnt.sv
module srs_bitcnt #(
    parameter int BITS = 8,
    localparam int CW = $clog2(BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= (cnt == CW'(BITS-1)) ? '0 : cnt + 1'b1;
    end

    assign last = en && (cnt == CW'(BITS-1));
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
    import srs_pkg::*;
#(
    parameter int          NUM_RW   = 7,
    parameter logic [7:0]  ID_VALUE = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [15:0]       adc0,
    input  logic [15:0]       adc1,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] store [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             store[g] <= '0;
            else if (we && waddr == ADDR_W'(g))     store[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NUM_RW) rdata = store[raddr];
        else begin
            unique case (raddr)
                4'hA:    rdata = ID_VALUE;
                4'hC:    rdata = adc0[7:0];
                4'hD:    rdata = adc0[15:8];
                4'hE:    rdata = adc1[7:0];
                4'hF:    rdata = adc1[15:8];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import srs_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h39,
    parameter logic [7:0] ID_VALUE = 8'h50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cond_start,
    input  logic        cond_rstart,
    input  logic        cond_stop,
    input  logic        bit_stb,
    input  logic        bit_val,
    input  logic [15:0] adc0_val,
    input  logic [15:0] adc1_val,
    output logic        ack_o,
    output logic        tx_en_o,
    output logic        tx_bit_o,
    output logic        wr_stb_o,
    output logic        rd_stb_o,
    output logic [3:0]  reg_addr_o,
    output logic [7:0]  wr_data_o
);
    localparam int SPACE = 1 << ADDR_W;

    srs_state_e        state, nxt;
    logic [BYTE_W-1:0] sh, rx_byte, rf_rdata, blk_cnt;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rem;
    logic              blk_q, ack_q, rw_q, last, shifting, any_start;

    assign any_start = cond_start | cond_rstart;
    assign rx_byte   = {sh[BYTE_W-2:0], bit_val};
    assign blk_cnt   = BYTE_W'(SPACE) - BYTE_W'(ptr);
    assign shifting  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_CNT)
                    || (state == ST_WDAT) || (state == ST_TX);

    srs_bitcnt #(.BITS(BYTE_W)) u_bitcnt (
        .clk(clk), .rst_n(rst_n),
        .clr(any_start | cond_stop),
        .en(bit_stb && shifting && !any_start && !cond_stop),
        .last(last)
    );

    srs_regfile #(.NUM_RW(7), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(wr_stb_o), .waddr(reg_addr_o), .wdata(wr_data_o),
        .raddr(ptr), .adc0(adc0_val), .adc1(adc1_val), .rdata(rf_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (any_start)      nxt = ST_ADDR;
        else if (cond_stop) nxt = ST_IDLE;
        else if (bit_stb) begin
            unique case (state)
                ST_ADDR:     if (last) nxt = ST_ADDR_ACK;
                ST_CMD:      if (last) nxt = ST_CMD_ACK;
                ST_CNT:      if (last) nxt = ST_CNT_ACK;
                ST_WDAT:     if (last) nxt = ST_WDAT_ACK;
                ST_TX:       if (last) nxt = ST_TX_ACK;
                ST_ADDR_ACK: nxt = !ack_q ? ST_WAIT : (rw_q ? ST_TX : ST_CMD);
                ST_CMD_ACK:  nxt = blk_q ? ST_CNT : ST_WDAT;
                ST_CNT_ACK:  nxt = ST_WDAT;
                ST_WDAT_ACK: nxt = ST_WDAT;
                ST_TX_ACK:   nxt = bit_val ? ST_WAIT : ST_TX;
                ST_IDLE:     nxt = ST_IDLE;
                ST_WAIT:     nxt = ST_WAIT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; ptr <= '0; rem <= '0;
            blk_q <= 1'b0; ack_q <= 1'b0; rw_q <= 1'b0;
            wr_stb_o <= 1'b0; rd_stb_o <= 1'b0;
            reg_addr_o <= '0; wr_data_o <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            rd_stb_o <= 1'b0;
            if (bit_stb && !any_start && !cond_stop) begin
                unique case (state)
                    ST_ADDR: begin
                        sh <= rx_byte;
                        if (last) begin
                            ack_q <= (rx_byte[7:1] == SLV_ADDR);
                            rw_q  <= rx_byte[0];
                        end
                    end
                    ST_CMD: begin
                        sh <= rx_byte;
                        if (last) begin
                            ptr   <= rx_byte[ADDR_W-1:0];
                            blk_q <= rx_byte[4];
                            ack_q <= 1'b1;
                        end
                    end
                    ST_CNT: begin
                        sh <= rx_byte;
                        if (last) begin
                            rem   <= rx_byte;
                            ack_q <= 1'b1;
                        end
                    end
                    ST_WDAT: begin
                        sh <= rx_byte;
                        if (last) begin
                            if (!blk_q || rem != '0) begin
                                ack_q      <= 1'b1;
                                wr_stb_o   <= 1'b1;
                                reg_addr_o <= ptr;
                                wr_data_o  <= rx_byte;
                                ptr        <= ptr + 1'b1;
                                if (blk_q) rem <= rem - 1'b1;
                            end else begin
                                ack_q <= 1'b0;
                            end
                        end
                    end
                    ST_TX: sh <= {sh[BYTE_W-2:0], 1'b1};
                    ST_ADDR_ACK: begin
                        if (ack_q && rw_q) begin
                            if (blk_q) begin
                                sh  <= blk_cnt;
                                rem <= blk_cnt;
                            end else begin
                                sh         <= rf_rdata;
                                rd_stb_o   <= 1'b1;
                                reg_addr_o <= ptr;
                                ptr        <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (!bit_val) begin
                            if (!blk_q || rem != '0) begin
                                sh         <= rf_rdata;
                                rd_stb_o   <= 1'b1;
                                reg_addr_o <= ptr;
                                ptr        <= ptr + 1'b1;
                                if (blk_q) rem <= rem - 1'b1;
                            end else begin
                                sh <= '1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        ack_o    = 1'b0;
        tx_en_o  = 1'b0;
        tx_bit_o = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WDAT_ACK: ack_o = ack_q;
            ST_TX: begin
                tx_en_o  = 1'b1;
                tx_bit_o = sh[BYTE_W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic cond_start,
    input logic cond_rstart,
    input logic cond_stop,
    input logic bit_stb,
    input logic ack_o,
    input logic tx_en_o,
    input logic tx_bit_o,
    input logic wr_stb_o,
    input logic rd_stb_o
);
    p_ack_not_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !tx_en_o);

    p_tx_bit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && !bit_stb && !cond_start && !cond_rstart && !cond_stop)
        |=> $stable(tx_bit_o));

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cond_stop |=> (!ack_o && !tx_en_o));

    p_start_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_start || cond_rstart) |=> (!ack_o && !tx_en_o));

    p_wr_needs_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(bit_stb));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb_o, rd_stb_o}));

    p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);
endmodule

bind smb_reg_slave srs_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .cond_start(cond_start), .cond_rstart(cond_rstart), .cond_stop(cond_stop),
    .bit_stb(bit_stb), .ack_o(ack_o), .tx_en_o(tx_en_o), .tx_bit_o(tx_bit_o),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o)
);

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
    localparam logic [6:0] SA  = 7'h39;
    localparam logic [7:0] IDV = 8'h50;
    localparam logic [7:0] AW  = {SA, 1'b0};
    localparam logic [7:0] AR  = {SA, 1'b1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cond_start = 0, cond_rstart = 0, cond_stop = 0, bit_stb = 0, bit_val = 0;
    logic [15:0] adc0_val = 16'hBEEF, adc1_val = 16'h1234;
    logic ack_o, tx_en_o, tx_bit_o, wr_stb_o, rd_stb_o;
    logic [3:0] reg_addr_o;
    logic [7:0] wr_data_o;
    int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;

    always #2.5 clk = ~clk;

    smb_reg_slave #(.SLV_ADDR(SA), .ID_VALUE(IDV)) uut (.*);

    always @(negedge clk) begin
        if (wr_stb_o) wr_cnt++;
        if (rd_stb_o) rd_cnt++;
    end

    // {addr, write data, expected read}
    localparam logic [19:0] VEC [10] = '{
        {4'h0, 8'h5A, 8'h5A}, {4'h1, 8'hA5, 8'hA5}, {4'h6, 8'hC3, 8'hC3},
        {4'h7, 8'h11, 8'h00}, {4'h8, 8'h22, 8'h00}, {4'h9, 8'h33, 8'h00},
        {4'hB, 8'h44, 8'h00}, {4'hA, 8'h77, IDV},   {4'hC, 8'h99, 8'hEF},
        {4'hD, 8'h98, 8'hBE}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        bit_val = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; bit_val = 1'b0;
    endtask

    task automatic cond(input int k);
        if (k == 0) cond_start = 1'b1;
        else if (k == 1) cond_rstart = 1'b1;
        else cond_stop = 1'b1;
        @(negedge clk);
        cond_start = 0; cond_rstart = 0; cond_stop = 0;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ak);
        for (int i = 7; i >= 0; i--) pulse(b[i]);
        ak = ack_o;
        pulse(1'b1);
    endtask

    task automatic rbyte(input logic mnack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            d = {d[6:0], tx_bit_o};
            pulse(1'b1);
        end
        pulse(mnack);
    endtask

    task automatic wr1(input logic [7:0] cmd, input logic [7:0] data, output logic ak);
        logic a;
        cond(0); wbyte(AW, a); wbyte(cmd, a); wbyte(data, ak); cond(2);
    endtask

    task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        cond(0); wbyte(AW, a); wbyte(cmd, a); cond(1); wbyte(AR, a);
        rbyte(1'b1, d); cond(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog act=1 exp=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a, a2, a3;
        logic [7:0] d, d2, d3;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(!ack_o && !tx_en_o && !wr_stb_o && !rd_stb_o, "R11 outputs idle",
            {ack_o, tx_en_o, wr_stb_o, rd_stb_o}, 0);
        rd1(8'h03, d);
        chk(d == 8'h00, "R11 storage reset", d, 0);

        // R8 R3 table walk: single write then single read
        for (int i = 0; i < 10; i++) begin
            wr1({4'h0, VEC[i][19:16]}, VEC[i][15:8], a);
            chk(a == 1'b1, "R3 data acked", a, 1);
            rd1({4'h0, VEC[i][19:16]}, d);
            chk(d == VEC[i][7:0], "R8 readback", d, VEC[i][7:0]);
        end
        chk(wr_cnt == 10, "R9 write strobes", wr_cnt, 10);

        // R1 address mismatch
        w0 = wr_cnt;
        cond(0);
        for (int i = 7; i >= 0; i--) pulse(i == 1 ? ~AW[i] : AW[i]);
        chk(ack_o == 1'b0, "R1 mismatch nack", ack_o, 0);
        pulse(1'b1);
        wbyte(8'h00, a); wbyte(8'hEE, a2);
        chk(!a && !a2 && wr_cnt == w0, "R1 ignored after mismatch", {a, a2}, 0);
        cond(2);
        rd1(8'h00, d);
        chk(d == 8'h5A, "R1 storage untouched", d, 8'h5A);

        // R3 R2 multi-byte write with wrap
        cond(0); wbyte(AW, a); wbyte(8'h0F, a);
        chk(a == 1'b1, "R2 command acked", a, 1);
        wbyte(8'h11, a); wbyte(8'h22, a2); wbyte(8'h33, a3); cond(2);
        chk(a && a2 && a3, "R3 wrap bytes acked", {a, a2, a3}, 7);
        // R5 multi-byte read with wrap from Fh
        cond(0); wbyte(AW, a); wbyte(8'h0F, a); cond(1); wbyte(AR, a);
        chk(tx_en_o == 1'b1, "R5 transmit enabled", tx_en_o, 1);
        rbyte(1'b0, d); rbyte(1'b0, d2); rbyte(1'b1, d3);
        chk(d == 8'h12, "R5 byte at Fh", d, 8'h12);
        chk(d2 == 8'h22 && d3 == 8'h33, "R3 wrapped writes", {d2, d3}, 16'h2233);
        // R7 master nack stops transmission
        chk(tx_en_o == 1'b0, "R7 tx off after nack", tx_en_o, 1'b0);
        pulse(1'b1); pulse(1'b0);
        chk(tx_en_o == 1'b0 && ack_o == 1'b0, "R7 stays quiet", tx_en_o, 0);
        cond(2);

        // R4 block write count 2, third byte nacked
        w0 = wr_cnt;
        cond(0); wbyte(AW, a); wbyte(8'h12, a); wbyte(8'h02, a);
        chk(a == 1'b1, "R4 count acked", a, 1);
        wbyte(8'hAA, a); wbyte(8'hBB, a2); wbyte(8'hCC, a3); cond(2);
        chk(a && a2 && !a3, "R4 acks", {a, a2, a3}, 6);
        chk(wr_cnt == w0 + 2, "R4 write strobes", wr_cnt, w0 + 2);
        cond(0); wbyte(AW, a); wbyte(8'h02, a); cond(1); wbyte(AR, a);
        rbyte(1'b0, d); rbyte(1'b0, d2); rbyte(1'b1, d3); cond(2);
        chk(d == 8'hAA && d2 == 8'hBB && d3 == 8'h00, "R4 stored bytes",
            {d, d2, d3}, 24'hAABB00);

        // R6 block read from Ch
        w0 = rd_cnt;
        cond(0); wbyte(AW, a); wbyte(8'h1C, a); cond(1); wbyte(AR, a);
        rbyte(1'b0, d);
        chk(d == 8'h04, "R6 block count", d, 4);
        rbyte(1'b0, d); rbyte(1'b0, d2);
        chk(d == 8'hEF && d2 == 8'hBE, "R6 channel 0", {d, d2}, 16'hEFBE);
        rbyte(1'b0, d); rbyte(1'b0, d2);
        chk(d == 8'h34 && d2 == 8'h12, "R6 channel 1", {d, d2}, 16'h3412);
        rbyte(1'b1, d);
        chk(d == 8'hFF, "R6 past count", d, 8'hFF);
        chk(rd_cnt == w0 + 4, "R9 read strobes", rd_cnt, w0 + 4);
        cond(2);

        // R10 stop in the middle of a transmitted byte
        cond(0); wbyte(AW, a); wbyte(8'h00, a); cond(1); wbyte(AR, a);
        pulse(1'b1); pulse(1'b1);
        cond(2);
        chk(!tx_en_o && !ack_o, "R10 stop mid-read", {tx_en_o, ack_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule